// File: doc/BRIEF.md
# Table-driven IQ container timeslot mapper

This block sits between a set of antenna-carrier sample channels and the IQ data part of a radio link. In the transmit direction, each time the link side asks for a timeslot, the block builds one 32-bit word from the sample pair of the channel that owns that timeslot. In the receive direction it takes one 32-bit word per valid timeslot, recovers the sample pair, and presents it on the owning channel. Control bytes of the line frame never reach this block. Only data timeslots do.

Each direction has its own table with one entry per timeslot of a container block. An entry holds an enable flag, a channel number and a start bit offset. A timeslot counter for each direction walks through the table and wraps at a programmed block length. A small CPU register port selects one table index at a time and exposes that index's receive entry and transmit entry. The same port holds a control word with the mapping-mode code, the sample width, the block length and a spare-timeslot count. Table writes go to a shadow copy. The working copy is refreshed only at a block boundary, or continuously while mapping is idle.

In 16-bit width mode a timeslot carries a 16-bit I and a 16-bit Q, and the start offset shifts the pair toward the LSB. In 15-bit width mode it carries a 15-bit I and a 15-bit Q, and the offset is not used. Mode code 01 maps every enabled timeslot, including those at the end of a block. Mode code 10 in 16-bit width mode turns the last few timeslots of each block into stuffing.

Top module: `tsmap_top`

## Requirements
- R1: After reset, tx_word is 0, tx_word_vld is 0, tx_take is 0 and rx_vld is 0. All four CPU registers read 0, and the mode is idle (code 00).
- R2: The CPU registers are addressed as 0 = index, 1 = receive entry, 2 = transmit entry and 3 = control. Entry bits are [15] enable, [12:8] start offset and [3:0] channel. Control bits are [1:0] mode, [4] 16-bit width, [11:8] block length minus one and [19:16] spare count. Writing the index register selects an entry. Registers 1 and 2 then read back the last value written to that index's receive and transmit entry, with the undefined bits reading 0. Entries at other indices are not disturbed.
- R3: In 16-bit width mode, a transmit request for an enabled timeslot owned by channel c gives tx_word = {I,Q} >> offset one cycle later. Bits above the shifted sample are zero. In that same cycle tx_take has only bit c set. tx_word_vld follows tx_slot_req with one cycle of latency.
- R4: In 16-bit width mode, a valid receive word w for an enabled timeslot of channel c gives {rx_i,rx_q} = w << offset one cycle later, with only bit c of rx_vld set. rx_vld is 0 in any cycle that follows a cycle without rx_word_vld.
- R5: In 15-bit width mode the offset is ignored. The transmit word is {I[14:0],Q[14:0],2'b00}. The receive outputs are rx_i = {0,w[31:17]} and rx_q = {0,w[16:2]}.
- R6: A timeslot whose entry has enable = 0, or whose channel number is not below the channel count, gives an all-zero transmit word with tx_take = 0. In the receive direction it is discarded, so rx_vld stays 0.
- R7: Each direction's timeslot counter moves forward only on a valid timeslot. It wraps to 0 after block length minus one, so the table pattern repeats every block. Gaps between timeslots do not move the counter.
- R8: With mode 10 and 16-bit width, a timeslot t is stuffing when t + spare > block length minus one. A stuffing timeslot gives a zero transmit word with no take, and its receive word is discarded. With mode 01, or in 15-bit width mode, the spare count has no effect.
- R9: Mode codes 00 and 11 are idle. Every transmit word is 0, no take or receive valid is raised, and both counters are held at 0.
- R10: Table writes made while mapping runs do not affect the rest of the current block. They take effect from the first timeslot of the next block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_addr | input | 2 | CPU register address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data for cpu_addr (combinational) |
| tx_i | input | NUM_CH*16 | Transmit I sample per channel, channel c at [16c+15:16c] |
| tx_q | input | NUM_CH*16 | Transmit Q sample per channel |
| tx_take | output | NUM_CH | One-hot pulse: the channel whose sample was consumed |
| tx_slot_req | input | 1 | Link side requests one transmit timeslot |
| tx_word | output | 32 | Transmit timeslot word |
| tx_word_vld | output | 1 | tx_word holds the answer to a request |
| rx_word | input | 32 | Received timeslot word |
| rx_word_vld | input | 1 | rx_word is a valid data timeslot |
| rx_i | output | 16 | Recovered I sample |
| rx_q | output | 16 | Recovered Q sample |
| rx_vld | output | NUM_CH | One-hot: the channel that owns rx_i/rx_q |

## Verification
Some properties are checked every cycle. These are the one-cycle latency from request to word, the one-hot form of take and receive valid, zero words whenever no channel is served, silence while idle, and the counter holding during gaps and returning to zero after a wrap. Other behaviour can only be shown by the bench scenarios, because it needs a model of the tables and the counters. That covers the exact bit placement for each offset, the 15-bit packing with the offset ignored, the difference between the two mode codes on spare timeslots, the CPU readback, and the rule that a table write made mid-block waits for the block boundary.

// File: rtl/tsmap_pkg.sv
package tsmap_pkg;
  localparam int SLOT_W = 32;
  localparam int HALF_W = 16;
  localparam int POS_W  = 5;
  localparam int CHF_W  = 4;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'b00,
    MODE_SAMPLE = 2'b01,
    MODE_COMPAT = 2'b10,
    MODE_RSVD   = 2'b11
  } map_mode_e;

  typedef struct packed {
    logic             en;
    logic [POS_W-1:0] pos;
    logic [CHF_W-1:0] ch;
  } slot_ent_t;

  function automatic slot_ent_t ent_from_reg(input logic [31:0] r);
    slot_ent_t e;
    e.en  = r[15];
    e.pos = r[12:8];
    e.ch  = r[3:0];
    return e;
  endfunction

  function automatic logic [31:0] ent_to_reg(input slot_ent_t e);
    return {16'd0, e.en, 2'b00, e.pos, 4'b0000, e.ch};
  endfunction

  // 16-bit width: pair placed MSB-first, starting pos bits below the top
  function automatic logic [SLOT_W-1:0] pack_wide(input logic [HALF_W-1:0] i,
                                                  input logic [HALF_W-1:0] q,
                                                  input logic [POS_W-1:0] pos);
    logic [SLOT_W-1:0] w;
    w = {i, q};
    return w >> pos;
  endfunction

  // 15-bit width: 30 data bits at the top, two unused LSBs
  function automatic logic [SLOT_W-1:0] pack_narrow(input logic [HALF_W-1:0] i,
                                                    input logic [HALF_W-1:0] q);
    return {i[14:0], q[14:0], 2'b00};
  endfunction

  function automatic logic [SLOT_W-1:0] unpack_wide(input logic [SLOT_W-1:0] w,
                                                    input logic [POS_W-1:0] pos);
    return w << pos;
  endfunction

  function automatic logic [SLOT_W-1:0] unpack_narrow(input logic [SLOT_W-1:0] w);
    return {1'b0, w[31:17], 1'b0, w[16:2]};
  endfunction

  function automatic logic mode_is_idle(input map_mode_e m);
    return (m == MODE_IDLE) || (m == MODE_RSVD);
  endfunction
endpackage

// File: rtl/tsmap_cfg.sv
module tsmap_cfg
  import tsmap_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [1:0]        cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  input  logic              tx_load,
  input  logic              rx_load,
  input  logic [IDX_W-1:0]  tx_idx,
  input  logic [IDX_W-1:0]  rx_idx,
  output slot_ent_t         tx_ent,
  output slot_ent_t         rx_ent,
  output map_mode_e         mode,
  output logic              wide16,
  output logic [IDX_W-1:0]  len_m1,
  output logic [IDX_W-1:0]  spare
);
  localparam logic [1:0] A_IDX = 2'd0;
  localparam logic [1:0] A_RXE = 2'd1;
  localparam logic [1:0] A_TXE = 2'd2;
  localparam logic [1:0] A_CTL = 2'd3;

  logic [IDX_W-1:0] sel_idx;
  logic             sel_ok;
  slot_ent_t        tx_shd [NUM_SLOTS];
  slot_ent_t        rx_shd [NUM_SLOTS];
  slot_ent_t        tx_act [NUM_SLOTS];
  slot_ent_t        rx_act [NUM_SLOTS];
  logic             unused_bits;

  assign sel_ok      = int'(sel_idx) < NUM_SLOTS;
  assign unused_bits = ^{cpu_wdata[31:20], cpu_wdata[7:5]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_idx <= '0;
      mode    <= MODE_IDLE;
      wide16  <= 1'b0;
      len_m1  <= '0;
      spare   <= '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        tx_shd[s] <= '0;
        rx_shd[s] <= '0;
      end
    end else if (cpu_wr) begin
      case (cpu_addr)
        A_IDX: sel_idx <= cpu_wdata[IDX_W-1:0];
        A_RXE: if (sel_ok) rx_shd[sel_idx] <= ent_from_reg(cpu_wdata);
        A_TXE: if (sel_ok) tx_shd[sel_idx] <= ent_from_reg(cpu_wdata);
        default: begin
          mode   <= map_mode_e'(cpu_wdata[1:0]);
          wide16 <= cpu_wdata[4];
          len_m1 <= cpu_wdata[8 +: IDX_W];
          spare  <= cpu_wdata[16 +: IDX_W];
        end
      endcase
    end
  end

  // working tables: refreshed only at a block boundary (or while idle)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        tx_act[s] <= '0;
        rx_act[s] <= '0;
      end
    end else begin
      if (tx_load) begin
        for (int s = 0; s < NUM_SLOTS; s++) tx_act[s] <= tx_shd[s];
      end
      if (rx_load) begin
        for (int s = 0; s < NUM_SLOTS; s++) rx_act[s] <= rx_shd[s];
      end
    end
  end

  always_comb begin
    tx_ent = (int'(tx_idx) < NUM_SLOTS) ? tx_act[tx_idx] : '0;
    rx_ent = (int'(rx_idx) < NUM_SLOTS) ? rx_act[rx_idx] : '0;
  end

  always_comb begin
    cpu_rdata = '0;
    case (cpu_addr)
      A_IDX: cpu_rdata[IDX_W-1:0] = sel_idx;
      A_RXE: if (sel_ok) cpu_rdata = ent_to_reg(rx_shd[sel_idx]);
      A_TXE: if (sel_ok) cpu_rdata = ent_to_reg(tx_shd[sel_idx]);
      A_CTL: begin
        cpu_rdata[1:0]          = mode;
        cpu_rdata[4]            = wide16;
        cpu_rdata[8 +: IDX_W]   = len_m1;
        cpu_rdata[16 +: IDX_W]  = spare;
      end
      default: cpu_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tsmap_seq.sv
module tsmap_seq #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             idle,
  input  logic             stuff_en,
  input  logic [IDX_W-1:0] len_m1,
  input  logic [IDX_W-1:0] spare,
  output logic [IDX_W-1:0] cnt,
  output logic             wrap,
  output logic             spare_slot,
  output logic             load
);
  logic [IDX_W:0] reach;

  assign wrap  = adv && !idle && (cnt >= len_m1);
  assign load  = idle || wrap;
  assign reach = {1'b0, cnt} + {1'b0, spare};
  assign spare_slot = stuff_en && (spare != '0) && (reach > {1'b0, len_m1});

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (idle)   cnt <= '0;
    else if (adv)    cnt <= wrap ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/tsmap_tx.sv
module tsmap_tx
  import tsmap_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req,
  input  slot_ent_t                ent,
  input  logic                     suppress,
  input  logic                     wide16,
  input  logic [NUM_CH*HALF_W-1:0] tx_i,
  input  logic [NUM_CH*HALF_W-1:0] tx_q,
  output logic [SLOT_W-1:0]        tx_word,
  output logic                     tx_word_vld,
  output logic [NUM_CH-1:0]        tx_take
);
  logic              hit;
  logic [HALF_W-1:0] sel_i, sel_q;
  logic [SLOT_W-1:0] nxt_word;
  logic [NUM_CH-1:0] take_oh;

  assign hit = req && ent.en && !suppress && (int'(ent.ch) < NUM_CH);

  always_comb begin
    sel_i = '0;
    sel_q = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ent.ch == CHF_W'(c)) begin
        sel_i = tx_i[c*HALF_W +: HALF_W];
        sel_q = tx_q[c*HALF_W +: HALF_W];
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_take
    assign take_oh[c] = hit && (ent.ch == CHF_W'(c));
  end

  always_comb begin
    if (!hit)        nxt_word = '0;
    else if (wide16) nxt_word = pack_wide(sel_i, sel_q, ent.pos);
    else             nxt_word = pack_narrow(sel_i, sel_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_word     <= '0;
      tx_word_vld <= 1'b0;
      tx_take     <= '0;
    end else begin
      tx_word     <= nxt_word;
      tx_word_vld <= req;
      tx_take     <= take_oh;
    end
  end
endmodule

// File: rtl/tsmap_rx.sv
module tsmap_rx
  import tsmap_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld,
  input  logic [SLOT_W-1:0] word,
  input  slot_ent_t         ent,
  input  logic              suppress,
  input  logic              wide16,
  output logic [HALF_W-1:0] rx_i,
  output logic [HALF_W-1:0] rx_q,
  output logic [NUM_CH-1:0] rx_vld
);
  logic              hit;
  logic [SLOT_W-1:0] un;
  logic [NUM_CH-1:0] vld_oh;

  assign hit = vld && ent.en && !suppress && (int'(ent.ch) < NUM_CH);
  assign un  = wide16 ? unpack_wide(word, ent.pos) : unpack_narrow(word);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_vld
    assign vld_oh[c] = hit && (ent.ch == CHF_W'(c));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_i   <= '0;
      rx_q   <= '0;
      rx_vld <= '0;
    end else begin
      rx_i   <= hit ? un[31:16] : '0;
      rx_q   <= hit ? un[15:0]  : '0;
      rx_vld <= vld_oh;
    end
  end
endmodule

// File: rtl/tsmap_top.sv
module tsmap_top
  import tsmap_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int NUM_SLOTS = 16,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cpu_wr,
  input  logic [1:0]               cpu_addr,
  input  logic [31:0]              cpu_wdata,
  output logic [31:0]              cpu_rdata,
  input  logic [NUM_CH*16-1:0]     tx_i,
  input  logic [NUM_CH*16-1:0]     tx_q,
  output logic [NUM_CH-1:0]        tx_take,
  input  logic                     tx_slot_req,
  output logic [31:0]              tx_word,
  output logic                     tx_word_vld,
  input  logic [31:0]              rx_word,
  input  logic                     rx_word_vld,
  output logic [15:0]              rx_i,
  output logic [15:0]              rx_q,
  output logic [NUM_CH-1:0]        rx_vld
);
  map_mode_e        mode;
  logic             wide16;
  logic [IDX_W-1:0] len_m1, spare;
  logic             map_idle, stuff_en;
  logic [IDX_W-1:0] tx_cnt, rx_cnt;
  logic             tx_wrap, rx_wrap, tx_spare, rx_spare, tx_load, rx_load;
  slot_ent_t        tx_ent, rx_ent;

  assign map_idle = mode_is_idle(mode);
  assign stuff_en = (mode == MODE_COMPAT) && wide16;

  tsmap_cfg #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .tx_load(tx_load), .rx_load(rx_load), .tx_idx(tx_cnt), .rx_idx(rx_cnt),
    .tx_ent(tx_ent), .rx_ent(rx_ent),
    .mode(mode), .wide16(wide16), .len_m1(len_m1), .spare(spare)
  );

  tsmap_seq #(.IDX_W(IDX_W)) u_tx_seq (
    .clk(clk), .rst_n(rst_n), .adv(tx_slot_req), .idle(map_idle), .stuff_en(stuff_en),
    .len_m1(len_m1), .spare(spare), .cnt(tx_cnt), .wrap(tx_wrap),
    .spare_slot(tx_spare), .load(tx_load)
  );

  tsmap_seq #(.IDX_W(IDX_W)) u_rx_seq (
    .clk(clk), .rst_n(rst_n), .adv(rx_word_vld), .idle(map_idle), .stuff_en(stuff_en),
    .len_m1(len_m1), .spare(spare), .cnt(rx_cnt), .wrap(rx_wrap),
    .spare_slot(rx_spare), .load(rx_load)
  );

  tsmap_tx #(.NUM_CH(NUM_CH)) u_tx (
    .clk(clk), .rst_n(rst_n), .req(tx_slot_req), .ent(tx_ent),
    .suppress(tx_spare || map_idle), .wide16(wide16),
    .tx_i(tx_i), .tx_q(tx_q),
    .tx_word(tx_word), .tx_word_vld(tx_word_vld), .tx_take(tx_take)
  );

  tsmap_rx #(.NUM_CH(NUM_CH)) u_rx (
    .clk(clk), .rst_n(rst_n), .vld(rx_word_vld), .word(rx_word), .ent(rx_ent),
    .suppress(rx_spare || map_idle), .wide16(wide16),
    .rx_i(rx_i), .rx_q(rx_q), .rx_vld(rx_vld)
  );
endmodule

// File: rtl/tsmap_chk.sv
module tsmap_chk #(
  parameter int NUM_CH = 4,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_slot_req,
  input logic              tx_word_vld,
  input logic [31:0]       tx_word,
  input logic [NUM_CH-1:0] tx_take,
  input logic              rx_word_vld,
  input logic [NUM_CH-1:0] rx_vld,
  input logic              map_idle,
  input logic              tx_wrap,
  input logic              rx_wrap,
  input logic [IDX_W-1:0]  tx_cnt,
  input logic [IDX_W-1:0]  rx_cnt
);
  AST_TX_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_slot_req |=> tx_word_vld); // R3
  AST_TX_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_slot_req |=> (!tx_word_vld && tx_word == '0 && tx_take == '0)); // R3
  AST_TAKE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_take)); // R3
  AST_RX_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_vld)); // R4
  AST_RX_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_word_vld |=> (rx_vld == '0)); // R4
  AST_UNSERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_word_vld && tx_take == '0) |-> (tx_word == '0)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    map_idle |=> (tx_take == '0 && rx_vld == '0)); // R9
  AST_IDLE_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    map_idle |=> (tx_cnt == '0 && rx_cnt == '0)); // R9
  AST_TX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wrap |=> (tx_cnt == '0)); // R7
  AST_RX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wrap |=> (rx_cnt == '0)); // R7
  AST_TX_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_slot_req && !map_idle) |=> $stable(tx_cnt)); // R7
  AST_RX_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_word_vld && !map_idle) |=> $stable(rx_cnt)); // R7
endmodule

bind tsmap_top tsmap_chk #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_slot_req(tx_slot_req), .tx_word_vld(tx_word_vld),
  .tx_word(tx_word), .tx_take(tx_take), .rx_word_vld(rx_word_vld), .rx_vld(rx_vld),
  .map_idle(map_idle), .tx_wrap(tx_wrap), .rx_wrap(rx_wrap),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/tb_tsmap_top.sv
`timescale 1ns/1ps
module tb_tsmap_top;
  localparam int NCH = 4;
  localparam int NSL = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_wr = 1'b0;
  logic [1:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic [NCH*16-1:0] tx_i = '0, tx_q = '0;
  logic [NCH-1:0] tx_take;
  logic tx_slot_req = 1'b0;
  logic [31:0] tx_word;
  logic tx_word_vld;
  logic [31:0] rx_word = '0;
  logic rx_word_vld = 1'b0;
  logic [15:0] rx_i, rx_q;
  logic [NCH-1:0] rx_vld;

  always #2.5 clk = ~clk;

  tsmap_top #(.NUM_CH(NCH), .NUM_SLOTS(NSL)) dut (.*);

  int n_chk = 0, n_fail = 0;

  // bench model of the block
  logic [15:0] m_txs [NSL], m_txa [NSL], m_rxs [NSL], m_rxa [NSL];
  int m_idx = 0, m_len = 0, m_spare = 0, tcnt = 0, rcnt = 0;
  logic [1:0] m_mode = 2'b00;
  bit m_wide = 0;

  // scoreboard queues
  logic [31:0] q_tw[$];
  logic [NCH-1:0] q_tt[$];
  string q_ttag[$];
  logic [NCH-1:0] q_rv[$];
  logic [15:0] q_ri[$], q_rq[$];
  string q_rtag[$];
  logic tx_cap = 1'b0, rx_cap = 1'b0;

  always @(posedge clk) begin
    tx_cap <= tx_slot_req;
    rx_cap <= rx_word_vld;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit m_idle();
    return (m_mode == 2'b00) || (m_mode == 2'b11);
  endfunction

  function automatic logic [15:0] ch_i(input logic [15:0] b, input int c);
    return b + 16'h0101 * 16'(c);
  endfunction
  function automatic logic [15:0] ch_q(input logic [15:0] b, input int c);
    return ~b - 16'(c);
  endfunction

  function automatic bit m_stuff(input int cnt);
    return (m_mode == 2'b10) && m_wide && (m_spare != 0) && (cnt + m_spare > m_len);
  endfunction

  task automatic cpu_write(input logic [1:0] a, input logic [31:0] d);
    bit was_idle;
    was_idle = m_idle();
    @(negedge clk);
    tx_slot_req = 1'b0; rx_word_vld = 1'b0;
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
    case (a)
      2'd0: m_idx = int'(d[3:0]);
      2'd1: m_rxs[m_idx] = d[15:0] & 16'h9F0F;
      2'd2: m_txs[m_idx] = d[15:0] & 16'h9F0F;
      default: begin
        m_mode = d[1:0]; m_wide = d[4]; m_len = int'(d[11:8]); m_spare = int'(d[19:16]);
      end
    endcase
    if (m_idle()) begin tcnt = 0; rcnt = 0; end
    if (was_idle || m_idle())
      for (int s = 0; s < NSL; s++) begin m_txa[s] = m_txs[s]; m_rxa[s] = m_rxs[s]; end
  endtask

  task automatic cpu_read(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    tx_slot_req = 1'b0; rx_word_vld = 1'b0;
    cpu_addr = a;
    #1;
    chk(cpu_rdata == exp, tag, "cpu readback", {32'd0, cpu_rdata}, {32'd0, exp});
  endtask

  function automatic logic [31:0] ctl(input int mode, input bit wide, input int lm1, input int sp);
    return 32'(mode) | (32'(wide) << 4) | (32'(lm1) << 8) | (32'(sp) << 16);
  endfunction

  task automatic tx_slot(input logic [15:0] base, input string tag);
    logic [15:0] e, si, sq;
    logic [31:0] w, o;
    logic [NCH-1:0] tk;
    int c, p;
    string tg;
    @(negedge clk);
    rx_word_vld = 1'b0;
    for (int k = 0; k < NCH; k++) begin
      tx_i[k*16 +: 16] = ch_i(base, k);
      tx_q[k*16 +: 16] = ch_q(base, k);
    end
    tx_slot_req = 1'b1;
    e = m_txa[tcnt]; c = int'(e[3:0]); p = int'(e[12:8]);
    tg = tag; o = '0; tk = '0;
    if (m_idle()) tg = "R9";
    else if (m_stuff(tcnt)) tg = "R8";
    else if (!e[15] || c >= NCH) tg = "R6";
    else begin
      si = ch_i(base, c); sq = ch_q(base, c);
      tk = NCH'(1) << c;
      if (m_wide) begin
        w = {si, sq};
        for (int b = 0; b < 32; b++) if (b >= p) o[31-b] = w[31-(b-p)];
      end else o = {si[14:0], sq[14:0], 2'b00};
    end
    q_tw.push_back(o); q_tt.push_back(tk); q_ttag.push_back(tg);
    if (!m_idle()) begin
      if (tcnt >= m_len) begin
        tcnt = 0;
        for (int s = 0; s < NSL; s++) m_txa[s] = m_txs[s];
      end else tcnt++;
    end
  endtask

  task automatic rx_slot(input logic [31:0] w, input string tag);
    logic [15:0] e;
    logic [31:0] o;
    logic [NCH-1:0] v;
    int c, p;
    string tg;
    @(negedge clk);
    tx_slot_req = 1'b0;
    rx_word = w; rx_word_vld = 1'b1;
    e = m_rxa[rcnt]; c = int'(e[3:0]); p = int'(e[12:8]);
    tg = tag; o = '0; v = '0;
    if (m_idle()) tg = "R9";
    else if (m_stuff(rcnt)) tg = "R8";
    else if (!e[15] || c >= NCH) tg = "R6";
    else begin
      v = NCH'(1) << c;
      if (m_wide) begin
        for (int b = 0; b < 32; b++) if (b + p <= 31) o[31-b] = w[31-b-p];
      end else o = {1'b0, w[31:17], 1'b0, w[16:2]};
    end
    q_rv.push_back(v); q_ri.push_back(o[31:16]); q_rq.push_back(o[15:0]); q_rtag.push_back(tg);
    if (!m_idle()) begin
      if (rcnt >= m_len) begin
        rcnt = 0;
        for (int s = 0; s < NSL; s++) m_rxa[s] = m_rxs[s];
      end else rcnt++;
    end
  endtask

  task automatic gap(input int n);
    repeat (n) begin
      @(negedge clk);
      tx_slot_req = 1'b0; rx_word_vld = 1'b0;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (tx_cap) begin
      if (q_tw.size() == 0) chk(1'b0, "R3", "unexpected tx word", 64'(tx_word), 64'd0);
      else begin
        logic [31:0] ew; logic [NCH-1:0] et; string tg;
        ew = q_tw.pop_front(); et = q_tt.pop_front(); tg = q_ttag.pop_front();
        chk(tx_word_vld && tx_word == ew && tx_take == et, tg, "tx {vld,take,word}",
            {27'd0, tx_word_vld, NCH'(tx_take), tx_word}, {27'd0, 1'b1, NCH'(et), ew});
      end
    end
    if (rx_cap) begin
      if (q_rv.size() == 0) chk(1'b0, "R4", "unexpected rx slot", 64'(rx_vld), 64'd0);
      else begin
        logic [NCH-1:0] ev; logic [15:0] ei, eq; string tg;
        ev = q_rv.pop_front(); ei = q_ri.pop_front(); eq = q_rq.pop_front(); tg = q_rtag.pop_front();
        chk(rx_vld == ev && (ev == '0 || (rx_i == ei && rx_q == eq)), tg, "rx {vld,i,q}",
            {28'd0, NCH'(rx_vld), rx_i, rx_q}, {28'd0, NCH'(ev), ei, eq});
      end
    end
  end

  task automatic run_block(input int n, input string tag, input int seed);
    for (int k = 0; k < n; k++) begin
      tx_slot(16'(seed * 977 + k * 313), (k >= 8) ? "R7" : tag);
      rx_slot(32'hA5C3_0F96 ^ (32'(k + seed) * 32'h0123_4567), (k >= 8) ? "R7" : tag);
      if (k % 3 == 2) gap(2);
    end
    gap(3);
  endtask

  initial begin
    for (int s = 0; s < NSL; s++) begin m_txs[s] = '0; m_txa[s] = '0; m_rxs[s] = '0; m_rxa[s] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(tx_word == 0 && !tx_word_vld && tx_take == 0, "R1", "tx after reset",
        {31'd0, tx_word_vld, tx_word}, 64'd0);
    chk(rx_vld == 0, "R1", "rx_vld after reset", 64'(rx_vld), 64'd0);
    for (int a = 0; a < 4; a++) cpu_read(2'(a), 32'd0, "R1");

    // R2 indexed entry access
    cpu_write(2'd0, 32'd3);
    cpu_write(2'd1, 32'hFFFF_8A02);
    cpu_write(2'd2, 32'h0000_8503);
    cpu_write(2'd0, 32'd5);
    cpu_write(2'd1, 32'h0000_1101);
    cpu_write(2'd2, 32'h0000_9F0E);
    cpu_read(2'd1, 32'h0000_1101, "R2");
    cpu_read(2'd2, 32'h0000_9F0E, "R2");
    cpu_write(2'd0, 32'd3);
    cpu_read(2'd0, 32'd3, "R2");
    cpu_read(2'd1, 32'h0000_8A02, "R2");
    cpu_read(2'd2, 32'h0000_8503, "R2");

    // program 8-slot tables
    for (int k = 0; k < 8; k++) begin
      logic [31:0] te, re;
      te = 32'h8000 | (32'((k * 3) % 32) << 8) | 32'(k % 4);
      if (k == 4) te = 32'h0000_0501;
      if (k == 7) te = 32'h0000_8209;
      re = 32'h8000 | (32'((k * 5) % 32) << 8) | 32'((k + 1) % 4);
      if (k == 2) re = 32'h0000_0302;
      cpu_write(2'd0, 32'(k));
      cpu_write(2'd2, te);
      cpu_write(2'd1, re);
    end
    cpu_write(2'd3, ctl(1, 1, 7, 0));
    cpu_read(2'd3, ctl(1, 1, 7, 0), "R2");

    // R3 R4 R7: sample-based, 16-bit, spare ignored by mode 01 (R8)
    run_block(16, "R3", 1);
    cpu_write(2'd3, ctl(0, 1, 7, 2));
    cpu_write(2'd3, ctl(1, 1, 7, 2));
    run_block(16, "R4", 2);

    // R8: backward-compatible, last 2 slots stuffing
    cpu_write(2'd3, ctl(0, 1, 7, 2));
    cpu_write(2'd3, ctl(2, 1, 7, 2));
    run_block(16, "R8", 3);

    // R5: 15-bit width, offsets and spare ignored in both codes
    cpu_write(2'd3, ctl(0, 0, 7, 2));
    cpu_write(2'd3, ctl(1, 0, 7, 2));
    run_block(8, "R5", 4);
    cpu_write(2'd3, ctl(0, 0, 7, 2));
    cpu_write(2'd3, ctl(2, 0, 7, 2));
    run_block(8, "R5", 5);

    // R9: reserved code acts idle
    cpu_write(2'd3, ctl(3, 1, 7, 0));
    run_block(4, "R9", 6);

    // R10: mid-block table change waits for the boundary
    cpu_write(2'd3, ctl(1, 1, 7, 0));
    for (int k = 0; k < 3; k++) begin
      tx_slot(16'(k * 101 + 7), "R10");
      rx_slot(32'h1357_9BDF + 32'(k), "R10");
    end
    cpu_write(2'd0, 32'd5);
    cpu_write(2'd2, 32'h0000_8103);
    cpu_write(2'd1, 32'h0000_8700);
    cpu_write(2'd0, 32'd4);
    cpu_write(2'd2, 32'h0000_8902);
    for (int k = 3; k < 16; k++) begin
      tx_slot(16'(k * 101 + 7), "R10");
      rx_slot(32'h1357_9BDF + 32'(k * 77), "R10");
    end
    gap(4);
    chk(q_tw.size() == 0 && q_rv.size() == 0, "R7", "scoreboard drained",
        64'(q_tw.size() + q_rv.size()), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R7 watchdog expired: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule